// File: doc/BRIEF.md
# Checkpoint Coordinator

This block runs a machine-wide checkpoint as a two-phase exchange over one broadcast level. On a trigger, either a pulse from outside or an internal interval timer, it raises the checkpoint level. While the level is high the cores stop issuing and save their state, the cache controllers copy out their contents, and the memory loggers flush their buffers. Each participant reports that its save or flush is done on its own acknowledge line. The coordinator records these reports in a sticky bitmap. When every bit is set it drops the level. That falling edge tells every participant to commit the new checkpoint at the same moment. The coordinator then gathers a second set of acknowledges, one per participant, for the commit.

A pause output stays high for the whole exchange so the cores can hold off. A sequence counter advances once for each checkpoint that finishes its commit. A trigger that arrives during an exchange is remembered and starts the next exchange as soon as the current commit completes. A phase that waits too long raises a sticky error flag.

The controller has three states. IDLE waits for a trigger. FLUSH drives the level high and gathers save/flush acknowledges. COMMIT drives the level low with pause still high and gathers commit acknowledges. The transitions are:
- start: IDLE to FLUSH, on a trigger, a pending trigger or a timer tick.
- release: FLUSH to COMMIT, once the flush bitmap is full.
- finish: COMMIT to IDLE, once the commit bitmap is full and nothing is pending.
- chain: COMMIT to FLUSH, once the commit bitmap is full and a trigger is pending or present.

Top module: `ckpt_coord`

## Requirements
- R1: After reset, ckpt_o, pause_o and err_o are 0 and seq_o is 0.
- R2: A trigger sampled in IDLE makes ckpt_o and pause_o read 1 after the next clock edge.
- R3: ckpt_o stays 1 until every bit of core_flush_i and log_flush_i has been seen high at least once during the FLUSH state. The bits may arrive as one-cycle pulses, in any order. ckpt_o reads 0 two edges after the edge that samples the last missing bit.
- R4: An acknowledge sampled outside its own phase has no effect. Flush bits seen in IDLE do not count toward the next FLUSH, and commit bits seen during FLUSH do not count toward the following COMMIT.
- R5: During COMMIT, ckpt_o is 0 and pause_o is 1. pause_o reads 0 two edges after the edge that samples the last missing bit of core_commit_i and log_commit_i. ckpt_o is never 1 while pause_o is 0.
- R6: seq_o increases by exactly one when a commit completes, wraps modulo 2^SEQ_W, and changes at no other time.
- R7: A trigger seen in FLUSH or COMMIT is held. When that commit completes, the next FLUSH starts on the same edge, so pause_o does not drop. Several triggers within one exchange start only one extra checkpoint.
- R8: If FLUSH or COMMIT lasts more than TIMEOUT_CYC cycles, err_o goes to 1 and stays 1 until reset. The cycle count restarts at each phase change, and the coordinator keeps waiting.
- R9: With PERIOD_CYC > 0, an internal trigger fires every PERIOD_CYC cycles, so successive rising edges of ckpt_o are PERIOD_CYC cycles apart while each exchange is shorter than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | External checkpoint request |
| core_flush_i | input | N_CORE | Save-done acknowledges from core/cache controllers |
| log_flush_i | input | N_LOG | Buffer-flushed acknowledges from memory loggers |
| core_commit_i | input | N_CORE | Commit-done acknowledges from core/cache controllers |
| log_commit_i | input | N_LOG | Commit-done acknowledges from memory loggers |
| ckpt_o | output | 1 | Broadcast checkpoint level |
| pause_o | output | 1 | High for the whole exchange; stalls the cores |
| seq_o | output | SEQ_W | Count of completed checkpoints |
| err_o | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The main instance is built with three core controllers, two loggers, a 16-cycle timeout, a 4-bit sequence counter and no interval timer. These values keep the bench short and still let it reach several cases: a flush phase that lasts exactly the timeout without tripping, a real timeout, and a sequence wrap from 15 to 0 inside the run. A second instance has its acknowledges tied high and a 20-cycle interval timer. It shows that the periodic trigger produces regularly spaced checkpoints.

// File: rtl/ckpt_coord_pkg.sv
package ckpt_coord_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_COMMIT = 2'd2
    } ckc_state_e;

endpackage

// File: rtl/ckc_ack_gather.sv
module ckc_ack_gather #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] ack_i,
    output logic         full_o
);

    logic [W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (clr_i) begin
            seen_q <= '0;
        end else if (en_i) begin
            seen_q <= seen_q | ack_i;
        end
    end

    assign full_o = &seen_q;

endmodule

// File: rtl/ckc_trigger.sv
module ckc_trigger #(
    parameter int PERIOD_CYC = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic busy_i,
    input  logic start_i,
    output logic fire_o
);

    logic tick;
    logic req;
    logic pend_q;

    generate
        if (PERIOD_CYC > 0) begin : g_timer
            localparam int PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
            localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);
            logic [PW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);
        end else begin : g_no_timer
            assign tick = 1'b0;
        end
    endgenerate

    assign req = trig_i | tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b0;
        end else if (req && busy_i) begin
            pend_q <= 1'b1;
        end
    end

    assign fire_o = req | pend_q;

endmodule

// File: rtl/ckc_timeout.sv
module ckc_timeout #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic restart_i,
    output logic err_o
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (active_i && !restart_i && (cnt_q == LIM)) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/ckpt_coord.sv
module ckpt_coord
    import ckpt_coord_pkg::*;
#(
    parameter int N_CORE      = 4,
    parameter int N_LOG       = 2,
    parameter int TIMEOUT_CYC = 1000,
    parameter int PERIOD_CYC  = 0,
    parameter int SEQ_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [N_CORE-1:0] core_flush_i,
    input  logic [N_LOG-1:0]  log_flush_i,
    input  logic [N_CORE-1:0] core_commit_i,
    input  logic [N_LOG-1:0]  log_commit_i,
    output logic              ckpt_o,
    output logic              pause_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic              err_o
);

    localparam int NP = N_CORE + N_LOG;

    ckc_state_e       state_q;
    ckc_state_e       state_d;
    logic             fire;
    logic             start;
    logic             commit_done;
    logic             flush_full;
    logic             commit_full;
    logic [SEQ_W-1:0] seq_q;

    ckc_trigger #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig_i),
        .busy_i  (state_q != ST_IDLE),
        .start_i (start),
        .fire_o  (fire)
    );

    ckc_ack_gather #(
        .W(NP)
    ) u_flush_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q != ST_FLUSH),
        .en_i   (state_q == ST_FLUSH),
        .ack_i  ({log_flush_i, core_flush_i}),
        .full_o (flush_full)
    );

    ckc_ack_gather #(
        .W(NP)
    ) u_commit_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q != ST_COMMIT),
        .en_i   (state_q == ST_COMMIT),
        .ack_i  ({log_commit_i, core_commit_i}),
        .full_o (commit_full)
    );

    ckc_timeout #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (state_q != ST_IDLE),
        .restart_i (state_d != state_q),
        .err_o     (err_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (flush_full) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (commit_full) state_d = fire ? ST_FLUSH : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign commit_done = (state_q == ST_COMMIT) && commit_full;
    assign start       = fire && ((state_q == ST_IDLE) || commit_done);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else if (commit_done) begin
            seq_q <= seq_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ckpt_o  = (state_q == ST_FLUSH);
        pause_o = (state_q != ST_IDLE);
        seq_o   = seq_q;
    end

endmodule

// File: rtl/ckpt_coord_chk.sv
module ckpt_coord_chk #(
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ckpt_o,
    input logic             pause_o,
    input logic             err_o,
    input logic [SEQ_W-1:0] seq_o,
    input logic             fire,
    input logic             flush_full,
    input logic             commit_full
);

    p_rise_on_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ckpt_o) |-> $past(fire));

    p_fall_needs_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ckpt_o) |-> $past(flush_full));

    p_level_inside_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_o |-> pause_o);

    p_pause_drop_needs_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pause_o) |-> $past(commit_full));

    p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_o) |-> (seq_o == SEQ_W'($past(seq_o) + 1'b1)));

    p_seq_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_o) |-> ($past(commit_full) && $past(pause_o) && !$past(ckpt_o)));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

bind ckpt_coord ckpt_coord_chk #(
    .SEQ_W(SEQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ckpt_o      (ckpt_o),
    .pause_o     (pause_o),
    .err_o       (err_o),
    .seq_o       (seq_o),
    .fire        (fire),
    .flush_full  (flush_full),
    .commit_full (commit_full)
);

// File: tb/ckpt_coord_tb.sv
module ckpt_coord_tb;

    localparam int NC   = 3;
    localparam int NL   = 2;
    localparam int TMO  = 16;
    localparam int SW   = 4;
    localparam int PER  = 20;
    localparam int NROW = 6;

    // gc, gl, hc, hl, expected flush length, expected commit length
    localparam int ROWS [NROW][6] = '{
        '{0,  0,  0,  0,  2,  2},
        '{3,  0,  0,  5,  5,  7},
        '{0,  4,  2,  1,  6,  4},
        '{7,  2,  9,  3,  9,  11},
        '{14, 1,  0,  14, 16, 16},
        '{10, 10, 10, 10, 12, 12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic [NC-1:0] core_flush = '0;
    logic [NL-1:0] log_flush = '0;
    logic [NC-1:0] core_commit = '0;
    logic [NL-1:0] log_commit = '0;
    logic          ckpt_o, pause_o, err_o;
    logic [SW-1:0] seq_o;
    logic          p_ckpt, p_pause, p_err;
    logic [SW-1:0] p_seq;

    int n_chk = 0;
    int n_fail = 0;
    int exp_seq = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ckpt_coord #(
        .N_CORE(NC), .N_LOG(NL), .TIMEOUT_CYC(TMO), .PERIOD_CYC(0), .SEQ_W(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .core_flush_i(core_flush), .log_flush_i(log_flush),
        .core_commit_i(core_commit), .log_commit_i(log_commit),
        .ckpt_o(ckpt_o), .pause_o(pause_o), .seq_o(seq_o), .err_o(err_o)
    );

    ckpt_coord #(
        .N_CORE(2), .N_LOG(1), .TIMEOUT_CYC(TMO), .PERIOD_CYC(PER), .SEQ_W(SW)
    ) u_per (
        .clk(clk), .rst_n(rst_n), .trig_i(1'b0),
        .core_flush_i(2'b11), .log_flush_i(1'b1),
        .core_commit_i(2'b11), .log_commit_i(1'b1),
        .ckpt_o(p_ckpt), .pause_o(p_pause), .seq_o(p_seq), .err_o(p_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic start_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic ack_flush_now();
        core_flush = '1; log_flush = '1;
        @(negedge clk);
        core_flush = '0; log_flush = '0;
        @(negedge clk);
    endtask

    task automatic ack_commit_now();
        core_commit = '1; log_commit = '1;
        @(negedge clk);
        core_commit = '0; log_commit = '0;
        @(negedge clk);
    endtask

    task automatic run_row(input int gc, input int gl, input int hc, input int hl,
                           output int fl, output int cl, output bit pause_ok, output bit lvl_ok);
        int k;
        start_trig();
        fl = 0; k = 0; pause_ok = 1'b1;
        while (ckpt_o === 1'b1 && fl < 100) begin
            fl++;
            if (pause_o !== 1'b1) pause_ok = 1'b0;
            core_flush = (k == gc) ? '1 : '0;
            log_flush  = (k == gl) ? '1 : '0;
            k++;
            @(negedge clk);
        end
        core_flush = '0; log_flush = '0;
        cl = 0; k = 0; lvl_ok = 1'b1;
        while (pause_o === 1'b1 && cl < 100) begin
            cl++;
            if (ckpt_o !== 1'b0) lvl_ok = 1'b0;
            core_commit = (k == hc) ? '1 : '0;
            log_commit  = (k == hl) ? '1 : '0;
            k++;
            @(negedge clk);
        end
        core_commit = '0; log_commit = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        int fl, cl;
        bit pok, lok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ckpt_o == 1'b0, "R1 ckpt", ckpt_o, 0);
        chk(pause_o == 1'b0, "R1 pause", pause_o, 0);
        chk(seq_o == '0, "R1 seq", seq_o, 0);
        chk(err_o == 1'b0, "R1 err", err_o, 0);

        // table of acknowledge timings: R3, R5, R6
        for (int r = 0; r < NROW; r++) begin
            run_row(ROWS[r][0], ROWS[r][1], ROWS[r][2], ROWS[r][3], fl, cl, pok, lok);
            exp_seq++;
            chk(fl == ROWS[r][4], "R3 flush length", fl, ROWS[r][4]);
            chk(cl == ROWS[r][5], "R5 commit length", cl, ROWS[r][5]);
            chk(pok && lok, "R5 level/pause relation", int'(pok && lok), 1);
            chk(int'(seq_o) == exp_seq % 16, "R6 seq after row", seq_o, exp_seq % 16);
            chk(err_o == 1'b0, "R8 no timeout within limit", err_o, 0);
        end

        // R2: trigger in idle raises level and pause on next edge
        chk(ckpt_o == 1'b0 && pause_o == 1'b0, "R2 idle before", ckpt_o, 0);
        start_trig();
        chk(ckpt_o == 1'b1, "R2 level", ckpt_o, 1);
        chk(pause_o == 1'b1, "R2 pause", pause_o, 1);
        // R3: one core bit missing keeps the level high
        core_flush = 3'b101; log_flush = '1;
        @(negedge clk);
        core_flush = '0; log_flush = '0;
        repeat (5) @(negedge clk);
        chk(ckpt_o == 1'b1, "R3 missing bit holds level", ckpt_o, 1);
        core_flush = 3'b010;
        @(negedge clk);
        core_flush = '0;
        chk(ckpt_o == 1'b1, "R3 one edge after last bit", ckpt_o, 1);
        @(negedge clk);
        chk(ckpt_o == 1'b0, "R3 drop after last bit", ckpt_o, 0);
        ack_commit_now();
        exp_seq++;
        chk(int'(seq_o) == exp_seq % 16, "R6 seq", seq_o, exp_seq % 16);

        // R4: acks outside their phase are ignored
        core_flush = '1; log_flush = '1; core_commit = '1; log_commit = '1;
        @(negedge clk);
        core_flush = '0; log_flush = '0; core_commit = '0; log_commit = '0;
        start_trig();
        repeat (3) @(negedge clk);
        chk(ckpt_o == 1'b1, "R4 idle flush acks ignored", ckpt_o, 1);
        core_flush = '1; log_flush = '1; core_commit = '1; log_commit = '1;
        @(negedge clk);
        core_flush = '0; log_flush = '0; core_commit = '0; log_commit = '0;
        @(negedge clk);
        chk(ckpt_o == 1'b0, "R4 flush phase over", ckpt_o, 0);
        repeat (4) @(negedge clk);
        chk(pause_o == 1'b1, "R4 early commit acks ignored", pause_o, 1);
        chk(int'(seq_o) == exp_seq % 16, "R4 seq held", seq_o, exp_seq % 16);
        ack_commit_now();
        exp_seq++;
        chk(pause_o == 1'b0, "R5 commit completes", pause_o, 0);

        // R7: triggers during an exchange chain one more checkpoint
        start_trig();
        trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        ack_flush_now();
        chk(ckpt_o == 1'b0 && pause_o == 1'b1, "R7 in commit", ckpt_o, 0);
        ack_commit_now();
        exp_seq++;
        chk(ckpt_o == 1'b1, "R7 chained start", ckpt_o, 1);
        chk(pause_o == 1'b1, "R7 pause held", pause_o, 1);
        chk(int'(seq_o) == exp_seq % 16, "R7 seq", seq_o, exp_seq % 16);
        ack_flush_now();
        ack_commit_now();
        exp_seq++;
        repeat (3) @(negedge clk);
        chk(pause_o == 1'b0, "R7 triggers merged", pause_o, 0);
        chk(int'(seq_o) == exp_seq % 16, "R7 seq after chain", seq_o, exp_seq % 16);

        // R6: run through the wrap
        while (exp_seq < 18) begin
            start_trig();
            ack_flush_now();
            ack_commit_now();
            exp_seq++;
            if (exp_seq == 16) chk(seq_o == '0, "R6 wrap to zero", seq_o, 0);
        end
        chk(int'(seq_o) == 2, "R6 after wrap", seq_o, 2);

        // R9: periodic trigger spacing
        begin
            int gap;
            bit prev;
            prev = p_ckpt;
            while (!(p_ckpt && !prev)) begin prev = p_ckpt; @(negedge clk); end
            for (int i = 0; i < 2; i++) begin
                gap = 0;
                prev = p_ckpt;
                @(negedge clk);
                gap++;
                while (!(p_ckpt && !prev)) begin prev = p_ckpt; @(negedge clk); gap++; end
                chk(gap == PER, "R9 periodic spacing", gap, PER);
            end
        end

        // R8: timeout and stickiness
        start_trig();
        repeat (15) @(negedge clk);
        chk(err_o == 1'b0, "R8 not yet timed out", err_o, 0);
        @(negedge clk);
        chk(err_o == 1'b1, "R8 timeout flag", err_o, 1);
        chk(ckpt_o == 1'b1, "R8 still waiting", ckpt_o, 1);
        ack_flush_now();
        ack_commit_now();
        exp_seq++;
        chk(err_o == 1'b1, "R8 sticky", err_o, 1);
        chk(int'(seq_o) == exp_seq % 16, "R8 completes late", seq_o, exp_seq % 16);

        // R1: reset clears everything again
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(err_o == 1'b0 && seq_o == '0, "R1 after reset", int'(err_o), 0);

        done = 1'b1;
        summary();
    end

endmodule